// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block turns one serial audio data line into parallel channel samples. All of its logic runs on the bit clock. A frame clock marks where each frame begins. Four run-time format inputs set how the line is read:

- the slot size, in bits;
- the number of audio bits carried in each slot;
- the bit order within a slot;
- the rule that decides when each channel after the first begins.

Each completed slot is presented as a 32-bit sample with the word MSB-aligned. The sample comes with its channel index and a one-cycle valid strobe.

In frame-clock-edge mode a frame carries two channels. Channel 0 begins at the rising frame-clock edge and channel 1 at the falling edge. In back-to-back mode, channel 0 begins at the rising edge and every later channel begins on the bit right after the previous slot. This continues up to a parameterised channel limit.

A system with several serial ports uses one instance per port, and each instance is configured on its own.

Top module: `serial_audio_rx`

## Requirements
- R1: The slot size code `slotLenSel` maps 00→24 bits, 01→20, 10→16 and 11→32. A slot always consumes exactly that many bit-clock cycles.
- R2: The word size code `wordLenSel` uses the same mapping. When the word is shorter than the slot, the line bits after the word have no effect on the sample.
- R3: When the word is longer than the slot, only slot-size bits are captured. The word bits that were not received read as zero.
- R4: With `lsbFirst`=0 the first slot bit is the word MSB. With `lsbFirst`=1 it is the word LSB. In both cases the word of W bits appears in `sampleOut[31:32-W]` and the lower bits are zero.
- R5: The bit clock samples on its rising edge. When `lrck` is first sampled high after being low, that edge starts a frame. Channel 0's first bit is sampled on the next rising edge.
- R6: With `chainStart`=0, channel 1's first bit is sampled on the edge after `lrck` is first sampled low. This holds even if channel 0 finished earlier. After channel 1 nothing is captured until the next frame.
- R7: With `chainStart`=1, channel c+1's first bit is sampled on the edge right after channel c's last bit. Channels run from 0 up to MAX_CH-1, and then capture stops until the next frame.
- R8: The edge that samples a slot's last bit raises `sampleValid` for exactly one cycle. At that edge `chanIdx` and `sampleOut` take that slot's channel and word. A slot that ends on the same edge as a frame start still completes.
- R9: The format inputs are taken only on the edge that starts a frame. Changes at any other time do not affect the frame in progress.
- R10: A frame start that arrives before the current slot's last bit abandons that slot with no valid strobe.
- R11: During and right after reset, `sampleValid`=0, `sampleOut`=0 and `chanIdx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; line sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck | input | 1 | Frame clock |
| sdata | input | 1 | Serial audio data |
| slotLenSel | input | 2 | Slot size code |
| wordLenSel | input | 2 | Audio word size code |
| lsbFirst | input | 1 | 1 = LSB first within a slot |
| chainStart | input | 1 | 1 = later channels follow back-to-back |
| sampleOut | output | 32 | MSB-aligned captured word |
| chanIdx | output | $clog2(MAX_CH) | Channel of the presented sample |
| sampleValid | output | 1 | One-cycle sample strobe |

## Verification
The bench goes after the edge-mode case where channel 0's last bit lands on the same edge as the falling frame edge. A design that checks the edge only while waiting would lose channel 1. It also covers a slot whose last bit coincides with the next frame start; a design that restarts too eagerly would drop that valid. Back-to-back frames whose length is not a multiple of the slot size cover the cut-off slot: a partial slot wrongly finishing would emit a spurious strobe. Format changes made mid-frame check that a design sampling the inputs live would shift the word or change the slot length partway through. Word sizes longer and shorter than the slot, in both bit orders, check that wrong placement shows up as shifted or junk bits.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int LEN_W    = 6;
  localparam int SAMPLE_W = 32;
  localparam int POS_W    = $clog2(SAMPLE_W);

  typedef struct packed {
    logic [1:0] slotCode;
    logic [1:0] wordCode;
    logic       lsbFirst;
    logic       chainMode;
  } fmt_t;

  // Strobes from control to datapath for the bit sampled at this edge
  typedef struct packed {
    logic             capture;
    logic             clear;
    logic             finish;
    logic [LEN_W-1:0] bitIdx;
    logic [LEN_W-1:0] wordLen;
    logic             lsbFirst;
  } strb_t;

  function automatic logic [LEN_W-1:0] codeToLen(input logic [1:0] code);
    case (code)
      2'b01:   return LEN_W'(20);
      2'b10:   return LEN_W'(16);
      2'b11:   return LEN_W'(32);
      default: return LEN_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int CH_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lrck,
  input  fmt_t            fmtIn,
  output strb_t           strb,
  output logic [CH_W-1:0] slotChan
);
  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_WAIT_FALL} state_t;

  state_t           state;
  logic             lrckQ;
  logic [LEN_W-1:0] bitCnt;
  logic [CH_W-1:0]  chan;
  fmt_t             fmt;

  logic             rise, fall, lastBit;
  logic [LEN_W-1:0] slotLen;

  assign rise    = lrck & ~lrckQ;
  assign fall    = ~lrck & lrckQ;
  assign slotLen = codeToLen(fmt.slotCode);
  assign lastBit = (state == ST_SLOT) && (bitCnt == slotLen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lrckQ  <= 1'b0;
      bitCnt <= '0;
      chan   <= '0;
      fmt    <= '0;
    end else begin
      lrckQ <= lrck;
      if (rise) begin
        // frame start: latch format, channel 0 begins next bit
        fmt    <= fmtIn;
        state  <= ST_SLOT;
        bitCnt <= '0;
        chan   <= '0;
      end else begin
        case (state)
          ST_SLOT: begin
            if (!lastBit) begin
              bitCnt <= bitCnt + LEN_W'(1);
            end else begin
              bitCnt <= '0;
              if (fmt.chainMode) begin
                if (chan == CH_W'(MAX_CH - 1)) state <= ST_IDLE;
                else                           chan  <= chan + CH_W'(1);
              end else if (chan == '0) begin
                if (fall) chan  <= CH_W'(1);
                else      state <= ST_WAIT_FALL;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_WAIT_FALL: begin
            if (fall) begin
              state  <= ST_SLOT;
              chan   <= CH_W'(1);
              bitCnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.capture  = (state == ST_SLOT);
    strb.clear    = (state == ST_SLOT) && (bitCnt == '0);
    strb.finish   = lastBit;
    strb.bitIdx   = bitCnt;
    strb.wordLen  = codeToLen(fmt.wordCode);
    strb.lsbFirst = fmt.lsbFirst;
  end

  assign slotChan = chan;
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdata,
  input  strb_t               strb,
  input  logic [CH_W-1:0]     slotChan,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [CH_W-1:0]     chanIdx,
  output logic                sampleValid
);
  logic [SAMPLE_W-1:0] acc, accNext;
  logic [POS_W-1:0]    pos;

  // each line bit goes straight to its MSB-aligned output position
  always_comb begin
    if (strb.lsbFirst)
      pos = POS_W'(SAMPLE_W - int'(strb.wordLen) + int'(strb.bitIdx));
    else
      pos = POS_W'(SAMPLE_W - 1 - int'(strb.bitIdx));
    accNext = strb.clear ? '0 : acc;
    if (strb.capture && (strb.bitIdx < strb.wordLen))
      accNext[pos] = sdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc         <= '0;
      sampleOut   <= '0;
      chanIdx     <= '0;
      sampleValid <= 1'b0;
    end else begin
      acc         <= accNext;
      sampleValid <= strb.finish;
      if (strb.finish) begin
        sampleOut <= accNext;
        chanIdx   <= slotChan;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int CH_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lrck,
  input  logic                sdata,
  input  logic [1:0]          slotLenSel,
  input  logic [1:0]          wordLenSel,
  input  logic                lsbFirst,
  input  logic                chainStart,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [CH_W-1:0]     chanIdx,
  output logic                sampleValid
);
  fmt_t            fmtIn;
  strb_t           ctrlStrb;
  logic [CH_W-1:0] slotChan;

  assign fmtIn = '{slotCode: slotLenSel, wordCode: wordLenSel,
                   lsbFirst: lsbFirst, chainMode: chainStart};

  sar_ctrl #(.MAX_CH(MAX_CH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .lrck     (lrck),
    .fmtIn    (fmtIn),
    .strb     (ctrlStrb),
    .slotChan (slotChan)
  );

  sar_datapath #(.CH_W(CH_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdata       (sdata),
    .strb        (ctrlStrb),
    .slotChan    (slotChan),
    .sampleOut   (sampleOut),
    .chanIdx     (chanIdx),
    .sampleValid (sampleValid)
  );
endmodule

// File: rtl/sar_chk.sv
module sar_chk
  import sar_pkg::*;
#(
  parameter int CH_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lrck,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic [CH_W-1:0]     chanIdx,
  input strb_t               strb,
  input logic [CH_W-1:0]     slotChan
);
  logic lrckSeen;
  logic riseSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) lrckSeen <= 1'b0;
    else        lrckSeen <= lrck;
  end
  assign riseSeen = lrck && !lrckSeen;

  assert_frame_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    riseSeen |=> (strb.clear && slotChan == '0));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish |=> (sampleValid && chanIdx == $past(slotChan)));

  assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> ((sampleOut << $past(strb.wordLen)) == '0));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.capture && !strb.clear) |-> ($stable(strb.wordLen) && $stable(strb.lsbFirst)));

  assert_bit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.capture && !strb.clear) |-> (strb.bitIdx == $past(strb.bitIdx) + LEN_W'(1)));
endmodule

bind serial_audio_rx sar_chk #(.CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lrck        (lrck),
  .sampleValid (sampleValid),
  .sampleOut   (sampleOut),
  .chanIdx     (chanIdx),
  .strb        (ctrlStrb),
  .slotChan    (slotChan)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  localparam int MAX_CH = 8;
  localparam int CH_W   = 3;

  logic clk = 1'b0, rst_n = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [1:0] slotSel = 2'b00, wordSel = 2'b00;
  logic lsbSel = 1'b0, chainSel = 1'b0;
  wire [31:0]     sampleOut;
  wire [CH_W-1:0] chanIdx;
  wire            sampleValid;

  serial_audio_rx #(.MAX_CH(MAX_CH)) u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata),
    .slotLenSel(slotSel), .wordLenSel(wordSel), .lsbFirst(lsbSel),
    .chainStart(chainSel), .sampleOut(sampleOut), .chanIdx(chanIdx),
    .sampleValid(sampleValid)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycCount = 0;
  bit monitorOn = 0, done = 0;
  logic carryBit = 1'b0;
  string curReq = "R11";

  int          edgeQ[$];
  int          chanQ[$];
  logic [31:0] valQ[$];
  string       reqQ[$];

  always @(posedge clk) cycCount <= cycCount + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycCount);
    end
  endtask

  function automatic int lenOf(input logic [1:0] code);
    case (code)
      2'b00: return 24;
      2'b01: return 20;
      2'b10: return 16;
      default: return 32;
    endcase
  endfunction

  // reference: every cycle either exactly the expected sample or no strobe
  always @(negedge clk) begin
    if (monitorOn) begin
      if (edgeQ.size() > 0 && edgeQ[0] == cycCount) begin
        check(sampleValid === 1'b1, reqQ[0], "valid", 64'(sampleValid), 64'd1);
        check(chanIdx == CH_W'(chanQ[0]), reqQ[0], "chanIdx", 64'(chanIdx), 64'(chanQ[0]));
        check(sampleOut == valQ[0], reqQ[0], "sampleOut", 64'(sampleOut), 64'(valQ[0]));
        void'(edgeQ.pop_front()); void'(chanQ.pop_front());
        void'(valQ.pop_front());  void'(reqQ.pop_front());
      end else begin
        check(sampleValid === 1'b0, curReq, "unexpected valid", 64'(sampleValid), 64'd0);
      end
    end
  end

  task automatic runFrame(input int half, input logic [1:0] sCode, input logic [1:0] wCode,
                          input logic lsb, input logic chain, input bit scramble, input string req);
    int S, W, base, st, tl;
    logic line [0:255];
    longint unsigned w, e;
    S = lenOf(sCode);
    W = lenOf(wCode);
    for (int t = 0; t <= 2 * half; t++) line[t] = 1'($urandom);
    line[0] = carryBit;
    @(negedge clk);
    base = cycCount + 1;
    curReq = req;
    for (int c = 0; c < MAX_CH; c++) begin
      if (chain) st = 1 + c * S;
      else begin
        if (c > 1) break;
        st = (c == 0) ? 1 : half + 1;
      end
      tl = st + S - 1;
      if (tl > 2 * half) break;
      w = 64'($urandom) & ((64'd1 << W) - 1);
      for (int j = 0; j < S && j < W; j++)
        line[st + j] = lsb ? w[j] : w[W - 1 - j];
      e = w;
      if (W > S) e = lsb ? (w & ((64'd1 << S) - 1)) : (w & ~((64'd1 << (W - S)) - 1));
      edgeQ.push_back(base + tl);
      chanQ.push_back(c);
      valQ.push_back(32'(e << (32 - W)));
      reqQ.push_back(req);
    end
    for (int t = 0; t < 2 * half; t++) begin
      if (t > 0) @(negedge clk);
      lrck  = (t < half);
      sdata = line[t];
      if (t == 0) begin
        slotSel = sCode; wordSel = wCode; lsbSel = lsb; chainSel = chain;
      end
      if (scramble && t == 3) begin
        slotSel = ~sCode; wordSel = ~wCode; lsbSel = ~lsb; chainSel = ~chain;
      end
    end
    carryBit = line[2 * half];
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check(sampleValid === 1'b0, "R11", "valid in reset", 64'(sampleValid), 64'd0);
    check(sampleOut === 32'd0, "R11", "sampleOut in reset", 64'(sampleOut), 64'd0);
    check(chanIdx === '0, "R11", "chanIdx in reset", 64'(chanIdx), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sampleValid === 1'b0 && sampleOut === 32'd0, "R11", "after reset", 64'(sampleOut), 64'd0);
    monitorOn = 1;

    runFrame(32, 2'b00, 2'b00, 1'b0, 1'b0, 0, "R1 R5 edge 24/24");
    runFrame(32, 2'b11, 2'b11, 1'b0, 1'b0, 0, "R6 R8 coincident edges 32/32");
    runFrame(32, 2'b10, 2'b10, 1'b0, 1'b0, 0, "R6 wait for falling edge 16/16");
    runFrame(64, 2'b10, 2'b10, 1'b0, 1'b1, 0, "R7 chain eight channels 16/16");
    runFrame(64, 2'b01, 2'b01, 1'b1, 1'b1, 0, "R1 R4 R10 chain lsb 20/20");
    runFrame(64, 2'b00, 2'b10, 1'b0, 1'b1, 0, "R2 word shorter msb");
    runFrame(64, 2'b10, 2'b00, 1'b1, 1'b1, 0, "R3 word longer lsb");
    runFrame(64, 2'b10, 2'b11, 1'b0, 1'b1, 0, "R3 word longer msb");
    runFrame(40, 2'b11, 2'b01, 1'b1, 1'b0, 0, "R2 R4 edge lsb 32/20");
    runFrame(64, 2'b00, 2'b00, 1'b0, 1'b1, 1, "R9 R10 chain with mid-frame change");
    runFrame(32, 2'b01, 2'b00, 1'b0, 1'b0, 1, "R9 R3 edge with mid-frame change");
    for (int k = 0; k < 24; k++) begin
      logic [1:0] sc, wc;
      logic ch;
      int hf;
      sc = 2'($urandom); wc = 2'($urandom); ch = 1'($urandom);
      hf = ch ? 32 + int'($urandom % 49) : lenOf(sc) + int'($urandom % 17);
      runFrame(hf, sc, wc, 1'($urandom), ch, 1'($urandom), "R1 R2 R3 R4 R7 mixed");
    end
    runFrame(32, 2'b10, 2'b10, 1'b0, 1'b0, 0, "R6 final frame");
    @(negedge clk);
    lrck = 1'b0; sdata = carryBit; curReq = "R6 tail";
    repeat (20) @(negedge clk);
    check(edgeQ.size() == 0, "R8", "expected samples left", 64'(edgeQ.size()), 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule